// File: doc/BRIEF.md
# I2C Arbitration and Address-Match Status Flags

This block runs next to an I2C bus controller and keeps three sticky status flags. The first is lost arbitration. The second is a hit on the first own address. The third is a hit on the second own address. It watches the synchronized SCL and SDA pin levels and compares them with the levels the controller itself is driving. It also watches the start-condition and address-frame strobes that the controller raises.

Software reads the flags through a 3-bit status value. A flag is cleared by writing 0 to it, and that write only works once the flag has been read as 1. Some flags also clear on their own. Lost arbitration clears on a data-register access that matches the transfer direction. The second-address flag clears when a start condition is seen or when the controller is in master mode.

Top module: `i2c_arb_addr_flags`

## Requirements
- R1: After reset, all three flags and the status read value are 0.
- R2: In master transmit mode, a rising SCL edge where `sda_drv` differs from `sda_pin` sets `arb_lost`. The edge is seen in the first clock in which `scl_pin` is 1 after a clock in which it was 0, and the flag reads 1 after that clock edge.
- R3: In master transmit mode, a falling SCL edge while `scl_drv` is still 1 sets `arb_lost`.
- R4: Outside master transmit mode (`is_master`=1 and `is_tx`=1), neither SCL edge condition sets `arb_lost`.
- R5: `arb_lost` clears on `dat_wr` when `is_tx`=1 and on `dat_rd` when `is_tx`=0. The access of the other kind leaves it unchanged.
- R6: A status write with bit i = 0 clears flag i only if a status read since the last status write returned flag i as 1. Writing 0 with no such read, or writing 1, leaves the flag unchanged. Any status write forgets earlier reads.
- R7: If a flag's hardware set condition fires after the status read and before the write-0, that write does not clear the flag.
- R8: When a set condition and a clear condition for a flag come in the same cycle, the flag ends up 1.
- R9: `addr1_hit` sets when the first `addr_done` after `start_det` has `addr_byte[7:1]` equal to `own_addr1`, or has `addr_byte` equal to 0x00. Later frames in the same transfer do not set it.
- R10: `addr2_hit` sets when that first frame has `addr_byte[7:1]` equal to `own_addr2`, but only with `is_master`=0, `is_tx`=0 and `addr2_fmt`=0.
- R11: `addr2_hit` clears on `start_det` and reads 0 while `is_master` is 1.
- R12: `sts_rdata` bit 0 is `arb_lost`, bit 1 is `addr1_hit` and bit 2 is `addr2_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pin | input | 1 | Synchronized SCL pin level |
| sda_pin | input | 1 | Synchronized SDA pin level |
| scl_drv | input | 1 | SCL level the controller drives (1 = released) |
| sda_drv | input | 1 | SDA level the controller drives (1 = released) |
| is_master | input | 1 | Controller is in master mode |
| is_tx | input | 1 | Controller is in transmit direction |
| own_addr1 | input | 7 | First own slave address |
| own_addr2 | input | 7 | Second own slave address |
| addr2_fmt | input | 1 | Second-address format select (0 enables matching) |
| start_det | input | 1 | Start-condition strobe |
| addr_done | input | 1 | Frame-complete strobe |
| addr_byte | input | 8 | Received frame: address in [7:1], R/W in [0] |
| sts_rd | input | 1 | CPU status-register read strobe |
| sts_wr | input | 1 | CPU status-register write strobe |
| sts_wdata | input | 3 | Status write data |
| dat_rd | input | 1 | CPU data-register read strobe |
| dat_wr | input | 1 | CPU data-register write strobe |
| arb_lost | output | 1 | Arbitration-lost flag |
| addr1_hit | output | 1 | First own address (or general call) recognized |
| addr2_hit | output | 1 | Second own address recognized |
| sts_rdata | output | 3 | Status read value |

## Verification
The hardest case to reach is the one where a flag's hardware set fires between the status read and the write-0 that would clear it. To get there, the bench reads a set `addr1_hit`, then runs a fresh start and a matching address frame, and only then writes 0. The flag must still read 1 after that write. A second case is a set and a clear in the same cycle: an SCL rise with an SDA mismatch is lined up with a transmit-mode data write, and the flag must end up 1.

// File: rtl/i2c_arb_addr_flags.sv
module i2c_arb_addr_flags #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_pin,
  input  logic          sda_pin,
  input  logic          scl_drv,
  input  logic          sda_drv,
  input  logic          is_master,
  input  logic          is_tx,
  input  logic [AW-1:0] own_addr1,
  input  logic [AW-1:0] own_addr2,
  input  logic          addr2_fmt,
  input  logic          start_det,
  input  logic          addr_done,
  input  logic [AW:0]   addr_byte,
  input  logic          sts_rd,
  input  logic          sts_wr,
  input  logic [2:0]    sts_wdata,
  input  logic          dat_rd,
  input  logic          dat_wr,
  output logic          arb_lost,
  output logic          addr1_hit,
  output logic          addr2_hit,
  output logic [2:0]    sts_rdata
);

  logic       scl_q, first_pend;
  logic [2:0] flag, rd1, hw_set, hw_clr, sw_clr;

  wire mtx      = is_master & is_tx;
  wire scl_rise = scl_pin & ~scl_q;
  wire scl_fall = ~scl_pin & scl_q;
  wire frame    = addr_done & first_pend;
  wire [AW-1:0] adr = addr_byte[AW:1];

  assign hw_set[0] = mtx & ((scl_rise & (sda_drv ^ sda_pin)) | (scl_fall & scl_drv));
  assign hw_set[1] = frame & ((adr == own_addr1) | (addr_byte == '0));
  assign hw_set[2] = frame & ~is_master & ~is_tx & ~addr2_fmt & (adr == own_addr2);

  assign hw_clr = {start_det | is_master, 1'b0, (dat_wr & is_tx) | (dat_rd & ~is_tx)};
  assign sw_clr = {3{sts_wr}} & ~sts_wdata & rd1;

  always_ff @(posedge clk) scl_q <= scl_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag       <= '0;
      rd1        <= '0;
      first_pend <= 1'b0;
    end else begin
      flag <= hw_set | (flag & ~(hw_clr | sw_clr));
      rd1  <= sts_wr ? 3'b000 : ((rd1 | ({3{sts_rd}} & flag)) & ~hw_set);
      if (start_det)      first_pend <= 1'b1;
      else if (addr_done) first_pend <= 1'b0;
    end
  end

  assign arb_lost  = flag[0];
  assign addr1_hit = flag[1];
  assign addr2_hit = flag[2];
  assign sts_rdata = flag;

endmodule

module i2c_arb_addr_flags_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_pin,
  input logic          sda_pin,
  input logic          scl_drv,
  input logic          sda_drv,
  input logic          is_master,
  input logic          is_tx,
  input logic          start_det,
  input logic          addr_done,
  input logic          sts_wr,
  input logic [2:0]    sts_wdata,
  input logic          arb_lost,
  input logic          addr1_hit,
  input logic          addr2_hit
);

  a_r2_rise_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && is_tx && !$past(scl_pin) && scl_pin && (sda_drv != sda_pin)) |=> arb_lost);

  a_r3_clock_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && is_tx && $past(scl_pin) && !scl_pin && scl_drv) |=> arb_lost);

  a_r4_no_set_outside_mtx: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_master && is_tx) |=> !$rose(arb_lost));

  a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr1_hit) |-> $past(sts_wr && !sts_wdata[1]));

  a_r11_master_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |=> !addr2_hit);

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !addr_done) |=> !addr2_hit);

endmodule

bind i2c_arb_addr_flags i2c_arb_addr_flags_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_i2c_arb_addr_flags.sv
module tb_i2c_arb_addr_flags;
  logic clk = 0, rst_n = 0;
  logic scl_pin = 1, sda_pin = 1, scl_drv = 0, sda_drv = 1;
  logic is_master = 0, is_tx = 0, addr2_fmt = 0;
  logic [6:0] own_addr1 = 0, own_addr2 = 0;
  logic start_det = 0, addr_done = 0, sts_rd = 0, sts_wr = 0, dat_rd = 0, dat_wr = 0;
  logic [7:0] addr_byte = 0;
  logic [2:0] sts_wdata = 0, sts_rdata;
  logic arb_lost, addr1_hit, addr2_hit;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_arb_addr_flags dut (.*);

  // {own1[26:20], own2[19:13], fmt[12], master[11], tx[10], byte[9:2], exp1[1], exp2[0]}
  localparam logic [26:0] VEC [8] = '{
    {7'h50, 7'h22, 1'b0, 1'b0, 1'b0, 8'hA0, 1'b1, 1'b0},
    {7'h50, 7'h22, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0, 1'b1},
    {7'h50, 7'h22, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {7'h50, 7'h22, 1'b1, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0},
    {7'h50, 7'h22, 1'b0, 1'b0, 1'b1, 8'h45, 1'b0, 1'b0},
    {7'h31, 7'h31, 1'b0, 1'b0, 1'b0, 8'h62, 1'b1, 1'b1},
    {7'h50, 7'h22, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0},
    {7'h50, 7'h22, 1'b0, 1'b1, 1'b0, 8'h44, 1'b0, 1'b0}
  };

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [2:0] exp);
    checks++;
    if ({addr2_hit, addr1_hit, arb_lost} !== exp || sts_rdata !== exp) begin
      fails++;
      $display("FAIL %s flags=%b rdata=%b expected=%b", tag,
               {addr2_hit, addr1_hit, arb_lost}, sts_rdata, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b);
    start_det = 1; cyc(); start_det = 0;
    addr_byte = b; addr_done = 1; cyc(); addr_done = 0;
  endtask

  task automatic rd(); sts_rd = 1; cyc(); sts_rd = 0; endtask
  task automatic wr(input logic [2:0] d); sts_wdata = d; sts_wr = 1; cyc(); sts_wr = 0; endtask
  task automatic clear_all(); rd(); wr(3'b000); endtask

  task automatic scl_rise_mm();
    scl_pin = 0; cyc(); sda_drv = 1; sda_pin = 0; scl_pin = 1; cyc(); sda_pin = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk("R1 reset", 3'b000);

    foreach (VEC[i]) begin
      own_addr1 = VEC[i][26:20]; own_addr2 = VEC[i][19:13];
      addr2_fmt = VEC[i][12]; is_master = VEC[i][11]; is_tx = VEC[i][10];
      frame(VEC[i][9:2]);
      chk($sformatf("R9/R10 vector %0d", i), {VEC[i][0], VEC[i][1], 1'b0});
      is_master = 0; is_tx = 0; addr2_fmt = 0;
      clear_all();
    end
    chk("R6 cleared after vectors", 3'b000);

    own_addr1 = 7'h50; own_addr2 = 7'h22;
    start_det = 1; cyc(); start_det = 0;
    addr_byte = 8'h12; addr_done = 1; cyc();
    addr_byte = 8'hA0; cyc(); addr_done = 0;
    chk("R9 later frame ignored", 3'b000);

    is_master = 1; is_tx = 1;
    scl_rise_mm();
    chk("R2 SDA mismatch at rise", 3'b001);
    chk("R12 status layout", 3'b001);
    dat_rd = 1; cyc(); dat_rd = 0;
    chk("R5 read in tx keeps", 3'b001);
    dat_wr = 1; cyc(); dat_wr = 0;
    chk("R5 write in tx clears", 3'b000);

    scl_drv = 1; scl_pin = 0; cyc(); scl_drv = 0; scl_pin = 1; cyc();
    chk("R3 SCL fall while driven high", 3'b001);
    is_tx = 0;
    dat_wr = 1; cyc(); dat_wr = 0;
    chk("R5 write in rx keeps", 3'b001);
    dat_rd = 1; cyc(); dat_rd = 0;
    chk("R5 read in rx clears", 3'b000);

    is_master = 0; is_tx = 1;
    scl_rise_mm();
    chk("R4 slave tx no set", 3'b000);
    is_master = 1; is_tx = 0;
    scl_rise_mm();
    chk("R4 master rx no set", 3'b000);

    is_tx = 1;
    scl_rise_mm();
    is_master = 0; is_tx = 0;
    wr(3'b000);
    chk("R6 write0 without read", 3'b001);
    rd(); wr(3'b111);
    chk("R6 write1 keeps", 3'b001);
    wr(3'b000);
    chk("R6 earlier read forgotten", 3'b001);
    rd(); wr(3'b000);
    chk("R6 read then write0 clears", 3'b000);

    frame(8'hA0);
    rd();
    frame(8'hA1);
    wr(3'b000);
    chk("R7 set between read and write survives", 3'b010);
    clear_all();
    chk("R7 later clear works", 3'b000);

    is_master = 1; is_tx = 1;
    scl_pin = 0; cyc();
    sda_pin = 0; scl_pin = 1; dat_wr = 1; cyc(); dat_wr = 0; sda_pin = 1;
    chk("R8 set wins over clear", 3'b001);
    dat_wr = 1; cyc(); dat_wr = 0;
    is_master = 0; is_tx = 0;

    frame(8'h44);
    chk("R10 addr2 set", 3'b100);
    is_master = 1; cyc(); is_master = 0;
    chk("R11 master clears addr2", 3'b000);
    frame(8'h44);
    start_det = 1; cyc(); start_det = 0;
    chk("R11 start clears addr2", 3'b000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule